// File: doc/BRIEF.md
# Tone Frequency Measurer with No-Tone Timeout

This block measures the frequency of a squared-up audio tone without knowing in advance which tone will arrive. A comparator upstream turns the received audio into a one-bit level, `zc_in`. The block counts reference clocks across a fixed number of input cycles. A band select picks that number so that every tone in the selected band gives a count inside one common 16-bit range. The host converts the count to hertz as f = f_ref * cycles / count. With a 4.032 MHz reference and the default base of 4 cycles, the three bands cover roughly 313–1500 Hz, 625–3000 Hz and 1250–6000 Hz, all mapping to counts of about 10752 to 51609.

A count is only reported after a coherence check. It must lie inside the count limits, and it must agree with the count of the window just before it within a tolerance of that previous count shifted right by `TOL_SH`. Accepted counts go out on a valid/ready result stream and are also signalled by a one-cycle strobe. A programmable no-tone timer runs in fixed ticks. It restarts on every accepted count, and it pulses `nt_expire` once if no accepted count arrives within the loaded period.

The result stream follows these back-pressure rules. `res_data` is held stable while `res_valid` is high and `res_ready` is low. An accepted count that arrives while the slot is still full is dropped from the stream but still strobes `meas_done`.

Top module: `tone_meter`

## Requirements
- R1: After reset, `res_valid`, `meas_done` and `nt_expire` are low and the no-tone period is 0.
- R2: The measured count is the number of clock cycles between the rising edge of `zc_in` that opens a window and the rising edge N rising edges later. N is `NCYC_BASE << b`, where b is `band_sel` for the codes 0, 1 and 2, and b = 2 for code 3. Windows run back to back, so the closing edge opens the next window.
- R3: A window count below `LIM_LO` or above `LIM_HI` is never reported, and it breaks the coherence chain, so the next in-range window is not reported either.
- R4: An in-range count is reported only if the previous window was in range and |count − previous| ≤ previous >> `TOL_SH`. The first window after a start or restart is never reported.
- R5: Each reported count produces exactly one single-cycle `meas_done` pulse, whatever the state of `res_ready`.
- R6: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` stays stable. A count accepted while the slot is full is discarded. After a handshake, `res_valid` goes low unless a new count arrives.
- R7: A cycle with `nt_load` high stores `nt_period` and restarts the timer. With a nonzero period P, `nt_expire` pulses exactly P*`TICK_CYC`+1 clock edges after the edge that samples the load, and no further pulse follows.
- R8: Every reported count restarts the no-tone timer from the stored period, so `nt_expire` follows the last `meas_done` pulse by P*`TICK_CYC`+1 cycles.
- R9: `nt_expire` is a single-cycle pulse, the timer stays stopped after expiry, and a stored period of 0 never expires.
- R10: If no rising edge arrives for more than `LIM_HI` cycles, the open window is abandoned and the coherence chain is cleared. The next tone then needs two fresh windows before its first report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_in | input | 1 | Squared-up tone level (asynchronous) |
| band_sel | input | 2 | Band code: 0 low, 1 mid, 2 or 3 high |
| nt_load | input | 1 | Load strobe for the no-tone period |
| nt_period | input | 8 | No-tone period in ticks (0 disables) |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_data | output | 16 | Measured count in reference clocks |
| meas_done | output | 1 | One-cycle strobe per accepted count |
| nt_expire | output | 1 | One-cycle no-tone expiry strobe |

## Verification
The bench uses a small configuration with the following parameters:
- `NCYC_BASE` = 2
- `LIM_LO` = 40
- `LIM_HI` = 200
- `TOL_SH` = 3
- `TICK_CYC` = 4

**Band sweeps.** For every band code, the bench sweeps the tone period across and past both count limits. The number and value of reports are compared with N*P, and only counts inside the limits may be reported. This separates correct window lengths and band decoding from off-by-one limit checks.

**Coherence checks.** Hand-built window pairs sit exactly on and one past the tolerance, both upward and downward. They separate a correct tolerance from an inclusive/exclusive or sign error. An idle gap between tones shows that the coherence chain is cleared.

**Back-pressure and timer.** A back-pressure run confirms that the held value stays stable and that a later count is dropped. Timer runs measure the exact expiry delay after a load and after the last report. They also confirm that a zero period never expires.

// File: rtl/tone_meter_pkg.sv
package tone_meter_pkg;

  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2,
    BAND_ALT  = 2'd3
  } band_e;

  // Shift applied to the base cycle count; the spare code aliases the high band.
  function automatic int unsigned band_shift(band_e b);
    case (b)
      BAND_LOW: return 0;
      BAND_MID: return 1;
      default:  return 2;
    endcase
  endfunction

endpackage

// File: rtl/tm_edge_sync.sv
module tm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  // sh[0..STAGES-1] synchronise, sh[STAGES] is the delayed copy for edge detect
  logic [STAGES:0] sh;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[g] <= 1'b0;
        else        sh[g] <= sh[g-1];
      end
    end
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/tm_gate_counter.sv
module tm_gate_counter
  import tone_meter_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NCYC_BASE = 4,
  parameter int LIM_HI    = 51609
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  band_e            band_i,
  output logic             win_done_o,
  output logic [CNT_W:0]   win_cnt_o,
  output logic             win_abort_o
);
  localparam int EDGE_W = $clog2(NCYC_BASE * 4 + 1);
  localparam logic [CNT_W:0] HI_V = (CNT_W + 1)'(LIM_HI);

  logic              armed_q;
  logic [EDGE_W-1:0] edges_q;
  logic [CNT_W:0]    cnt_q;
  logic [EDGE_W-1:0] last_edge;

  // number of edges inside one window, minus one
  assign last_edge = (EDGE_W'(NCYC_BASE) << band_shift(band_i)) - EDGE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      edges_q     <= '0;
      cnt_q       <= '0;
      win_done_o  <= 1'b0;
      win_cnt_o   <= '0;
      win_abort_o <= 1'b0;
    end else begin
      win_done_o  <= 1'b0;
      win_abort_o <= 1'b0;
      if (!armed_q) begin
        if (rise_i) begin
          armed_q <= 1'b1;
          cnt_q   <= (CNT_W + 1)'(1);
          edges_q <= '0;
        end
      end else if (rise_i) begin
        if (edges_q == last_edge) begin
          win_done_o <= 1'b1;
          win_cnt_o  <= cnt_q;
          cnt_q      <= (CNT_W + 1)'(1);
          edges_q    <= '0;
        end else begin
          edges_q <= edges_q + 1'b1;
          cnt_q   <= cnt_q + 1'b1;
        end
      end else if (cnt_q > HI_V) begin
        armed_q     <= 1'b0;
        win_abort_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R10: an abandoned window never also closes in the same cycle
  assert_abort_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_abort_o && win_done_o));

endmodule

// File: rtl/tm_quality.sv
module tm_quality #(
  parameter int CNT_W  = 16,
  parameter int LIM_LO = 10752,
  parameter int LIM_HI = 51609,
  parameter int TOL_SH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_done_i,
  input  logic [CNT_W:0]   win_cnt_i,
  input  logic             win_abort_i,
  output logic             acc_o,
  output logic [CNT_W-1:0] acc_cnt_o
);
  localparam logic [CNT_W:0] LO_V = (CNT_W + 1)'(LIM_LO);
  localparam logic [CNT_W:0] HI_V = (CNT_W + 1)'(LIM_HI);

  logic [CNT_W:0] prev_q;
  logic           prev_ok_q;
  logic           in_rng;
  logic [CNT_W:0] diff;
  logic           coherent;

  always_comb begin
    in_rng   = (win_cnt_i >= LO_V) && (win_cnt_i <= HI_V);
    diff     = (win_cnt_i > prev_q) ? (win_cnt_i - prev_q) : (prev_q - win_cnt_i);
    coherent = prev_ok_q && (diff <= (prev_q >> TOL_SH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
      acc_o     <= 1'b0;
      acc_cnt_o <= '0;
    end else begin
      acc_o <= 1'b0;
      if (win_abort_i) begin
        prev_ok_q <= 1'b0;
      end else if (win_done_i) begin
        if (in_rng) begin
          acc_o     <= coherent;
          acc_cnt_o <= win_cnt_i[CNT_W-1:0];
          prev_q    <= win_cnt_i;
          prev_ok_q <= 1'b1;
        end else begin
          prev_ok_q <= 1'b0;
        end
      end
    end
  end

  // R3: every accepted count lies within the band limits
  assert_acc_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> ((CNT_W + 1)'(acc_cnt_o) >= LO_V) && ((CNT_W + 1)'(acc_cnt_o) <= HI_V));

  // R4: an acceptance is always caused by a window closing one cycle earlier
  assert_acc_from_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> $past(win_done_i));

endmodule

// File: rtl/tm_notone_timer.sv
module tm_notone_timer #(
  parameter int PER_W    = 8,
  parameter int TICK_CYC = 40320
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PER_W-1:0] load_val_i,
  input  logic             reload_i,
  output logic             expire_o
);
  localparam int PRE_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_CYC - 1);

  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] tmr_q;
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q    <= '0;
      tmr_q    <= '0;
      pre_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (load_i) begin
        per_q <= load_val_i;
        tmr_q <= load_val_i;
        pre_q <= '0;
      end else if (reload_i) begin
        tmr_q <= per_q;
        pre_q <= '0;
      end else if (tmr_q != '0) begin
        if (pre_q == PRE_MAX) begin
          pre_q    <= '0;
          tmr_q    <= tmr_q - 1'b1;
          expire_o <= (tmr_q == PER_W'(1));
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  // R9: expiry is a single-cycle pulse and leaves the timer stopped
  assert_expire_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
  assert_expire_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (tmr_q == '0));

  // R7: a load restarts the timer from the loaded value
  assert_load_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (tmr_q == $past(load_val_i)) && (pre_q == '0));

endmodule

// File: rtl/tone_meter.sv
module tone_meter
  import tone_meter_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NCYC_BASE   = 4,
  parameter int LIM_LO      = 10752,
  parameter int LIM_HI      = 51609,
  parameter int TOL_SH      = 5,
  parameter int TICK_CYC    = 40320,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_in,
  input  logic [1:0]       band_sel,
  input  logic             nt_load,
  input  logic [PER_W-1:0] nt_period,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CNT_W-1:0] res_data,
  output logic             meas_done,
  output logic             nt_expire
);
  logic             rise;
  logic             win_done;
  logic [CNT_W:0]   win_cnt;
  logic             win_abort;
  logic             acc;
  logic [CNT_W-1:0] acc_cnt;

  tm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(zc_in), .rise_o(rise)
  );

  tm_gate_counter #(.CNT_W(CNT_W), .NCYC_BASE(NCYC_BASE), .LIM_HI(LIM_HI)) gate_i (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .band_i(band_e'(band_sel)),
    .win_done_o(win_done), .win_cnt_o(win_cnt), .win_abort_o(win_abort)
  );

  tm_quality #(.CNT_W(CNT_W), .LIM_LO(LIM_LO), .LIM_HI(LIM_HI), .TOL_SH(TOL_SH)) qual_i (
    .clk(clk), .rst_n(rst_n), .win_done_i(win_done), .win_cnt_i(win_cnt),
    .win_abort_i(win_abort), .acc_o(acc), .acc_cnt_o(acc_cnt)
  );

  tm_notone_timer #(.PER_W(PER_W), .TICK_CYC(TICK_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .load_i(nt_load), .load_val_i(nt_period),
    .reload_i(acc), .expire_o(nt_expire)
  );

  assign meas_done = acc;

  // single-entry result slot; a full, unaccepted slot keeps its value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (acc && (!res_valid || res_ready)) begin
        res_valid <= 1'b1;
        res_data  <= acc_cnt;
      end
    end
  end

  // R6: a stalled result holds valid and data
  assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_data));

  // R5: completion strobes are single-cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_done);

endmodule

// File: tb/tone_meter_tb_top.sv
`timescale 1ns/1ps
module tone_meter_tb_top;
  localparam int NB = 2, LO = 40, HI = 200, TSH = 3, TICK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc_in = 1'b0;
  logic [1:0] band_sel = 2'd0;
  logic nt_load = 1'b0;
  logic [7:0] nt_period = 8'd0;
  logic res_ready = 1'b1;
  logic res_valid, meas_done, nt_expire;
  logic [15:0] res_data;

  always #2 clk = ~clk;

  tone_meter #(.CNT_W(16), .NCYC_BASE(NB), .LIM_LO(LO), .LIM_HI(HI), .TOL_SH(TSH),
               .TICK_CYC(TICK), .PER_W(8), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .band_sel(band_sel),
    .nt_load(nt_load), .nt_period(nt_period), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .meas_done(meas_done),
    .nt_expire(nt_expire)
  );

  int checks = 0, fails = 0;
  int cyc = 0, md_cnt = 0, hs_cnt = 0, bad_cnt = 0, ex_cnt = 0;
  int md_cyc = 0, ex_cyc = 0, ld_cyc = 0;
  int exp_val = 0;
  logic [15:0] hs_last = '0;

  // monitor: samples at the falling edge, inputs change 1 ns after the rising edge
  always @(negedge clk) begin
    cyc++;
    if (meas_done) begin md_cnt++; md_cyc = cyc; end
    if (res_valid && res_ready) begin
      hs_cnt++; hs_last = res_data;
      if (int'(res_data) != exp_val) bad_cnt++;
    end
    if (nt_expire) begin ex_cnt++; ex_cyc = cyc; end
    if (nt_load) ld_cyc = cyc;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_gap(input int g);
    zc_in = 1'b1; step(g / 2);
    zc_in = 1'b0; step(g - g / 2);
  endtask

  // one window (band 0, two edges per window) per entry; n entries used
  task automatic run_windows(input int n, input int w0, input int w1, input int w2);
    int w[3];
    w[0] = w0; w[1] = w1; w[2] = w2;
    for (int i = 0; i < n; i++) begin
      pulse_gap(w[i] / 2);
      pulse_gap(w[i] - w[i] / 2);
    end
    pulse_gap(10);
    step(300);
  endtask

  task automatic run_tone(input int p, input int nedges);
    repeat (nedges) pulse_gap(p);
    step(300);
  endtask

  initial begin : watchdog
    #760000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int m0, h0, b0, e0, n, d, er;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(res_valid == 0, "R1 res_valid after reset", res_valid, 0);
    chk(meas_done == 0, "R1 meas_done after reset", meas_done, 0);
    chk(nt_expire == 0, "R1 nt_expire after reset", nt_expire, 0);

    // R2/R3: sweep every band code across and past both limits
    for (int b = 0; b < 4; b++) begin
      band_sel = 2'(b);
      n = NB << ((b == 3) ? 2 : b);
      for (int p = 2; p * n <= HI + 3 * n; p++) begin
        d = p * n;
        if (b < 3 && p % 2 == 1 && !(d >= LO - n && d <= LO + n) && !(d >= HI - n && d <= HI + n))
          continue;
        exp_val = d;
        er = (d >= LO && d <= HI) ? 4 : 0;
        m0 = md_cnt; h0 = hs_cnt; b0 = bad_cnt;
        run_tone(p, 1 + 5 * n);
        chk(md_cnt - m0 == er, $sformatf("R2 R3 R5 band=%0d count=%0d reports", b, d), md_cnt - m0, er);
        chk(hs_cnt - h0 == er, $sformatf("R2 R6 band=%0d count=%0d handshakes", b, d), hs_cnt - h0, er);
        chk(bad_cnt == b0, $sformatf("R2 band=%0d value", b), int'(hs_last), d);
      end
    end
    band_sel = 2'd0;

    // R4: tolerance on both sides, previous window 80 -> tolerance 10
    m0 = md_cnt; b0 = bad_cnt; exp_val = 90;
    run_windows(2, 80, 90, 0);
    chk(md_cnt - m0 == 1 && bad_cnt == b0, "R4 +10 accepted", md_cnt - m0, 1);
    m0 = md_cnt;
    run_windows(2, 80, 91, 0);
    chk(md_cnt - m0 == 0, "R4 +11 rejected", md_cnt - m0, 0);
    m0 = md_cnt; b0 = bad_cnt; exp_val = 70;
    run_windows(2, 80, 70, 0);
    chk(md_cnt - m0 == 1 && bad_cnt == b0, "R4 -10 accepted", md_cnt - m0, 1);
    m0 = md_cnt;
    run_windows(2, 80, 69, 0);
    chk(md_cnt - m0 == 0, "R4 -11 rejected", md_cnt - m0, 0);
    m0 = md_cnt;
    run_windows(3, 80, 30, 80);
    chk(md_cnt - m0 == 0, "R3 out-of-range window breaks chain", md_cnt - m0, 0);

    // R10: an idle gap clears the chain
    m0 = md_cnt;
    run_windows(1, 80, 0, 0);
    run_windows(2, 80, 80, 0);
    chk(md_cnt - m0 == 1, "R10 chain cleared by idle gap", md_cnt - m0, 1);

    // R6: back-pressure
    res_ready = 1'b0; m0 = md_cnt; h0 = hs_cnt; exp_val = 84;
    run_windows(3, 80, 84, 88);
    chk(md_cnt - m0 == 2, "R5 strobes while stalled", md_cnt - m0, 2);
    chk(res_valid == 1, "R6 valid held while stalled", res_valid, 1);
    chk(res_data == 16'd84, "R6 first value held, later dropped", res_data, 84);
    b0 = bad_cnt;
    res_ready = 1'b1; step(1);
    chk(hs_cnt - h0 == 1 && bad_cnt == b0, "R6 handshake value", int'(hs_last), 84);
    step(1);
    chk(res_valid == 0, "R6 valid drops after handshake", res_valid, 0);

    // R7/R9: timer after load
    e0 = ex_cnt;
    nt_period = 8'd10; nt_load = 1'b1; step(1); nt_load = 1'b0;
    step(100);
    chk(ex_cnt - e0 == 1, "R7 one expiry after load", ex_cnt - e0, 1);
    chk(ex_cyc - ld_cyc == 10 * TICK + 1, "R7 expiry delay", ex_cyc - ld_cyc, 10 * TICK + 1);
    step(100);
    chk(ex_cnt - e0 == 1, "R9 timer stays stopped", ex_cnt - e0, 1);
    e0 = ex_cnt;
    nt_period = 8'd0; nt_load = 1'b1; step(1); nt_load = 1'b0;
    step(300);
    chk(ex_cnt == e0, "R9 zero period never expires", ex_cnt - e0, 0);

    // R8: reports restart the timer
    e0 = ex_cnt; m0 = md_cnt; exp_val = 80;
    nt_period = 8'd60; nt_load = 1'b1; step(1); nt_load = 1'b0;
    run_tone(40, 11);
    step(300);
    chk(md_cnt - m0 == 4, "R8 reports during tone", md_cnt - m0, 4);
    chk(ex_cnt - e0 == 1, "R8 single expiry after tone", ex_cnt - e0, 1);
    chk(ex_cyc - md_cyc == 60 * TICK + 1, "R8 expiry delay after last report",
        ex_cyc - md_cyc, 60 * TICK + 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule